// File: doc/BRIEF.md
# Multi-Mode Serial Interface

This block is an 8-bit serial port that offers three framings and a single shift datapath. In clocked mode it shifts a byte out and a byte in at the same time while it generates the transfer clock. In UART mode it sends a start bit, the byte and a stop bit on a half-duplex line, and while idle it listens for an incoming frame. In bus mode it generates the clock, drives one low start slot and then shifts the byte. The data order is least significant bit first in all three modes.

Software-facing logic writes a byte and a mode, pulses a start strobe, and waits for the done flag. A period input gives the length of one bit in system clock cycles. The block limits that period to the legal range of the selected mode, so an out-of-range setting still produces a well-formed frame. Received bytes appear on a holding output. In UART mode a bad stop bit sets an error flag.

Top module: `mmsi_top`

## Requirements
- R1: After reset, and whenever the block is idle, `sdo_o` and `sck_o` are 1 and `busy_o` is 0. Reset also clears `done_o`, `frame_err_o` and `rx_data_o`.
- R2: The bit period P is taken from `div_i` when a frame begins. In modes 0 and 2 it is limited to the range 2 to 512. In mode 1 it is limited to the range 8 to 2048.
- R3: Mode encoding is 0 = clocked, 1 = UART, 2 = bus, and 3 behaves as 0. In clocked mode a frame has 8 slots that carry bits 0 to 7 in order. In each slot `sck_o` is low for the first floor(P/2) cycles and high for the remaining cycles. `sdo_o` changes only at the start of a slot, which is the falling clock edge. `sdi_i` is captured when `sck_o` rises.
- R4: In bus mode a frame has 9 clocked slots. Slot 0 drives `sdo_o` low. Slots 1 to 8 carry bits 0 to 7, and only those slots are shifted into the received byte.
- R5: In UART mode transmission, `sdo_o` goes through a low start slot, data bits 0 to 7 and a high stop slot, each P cycles long, and `sck_o` stays 1 throughout.
- R6: While idle with mode 1 selected, a low `sdi_i` starts a reception. The line is sampled again P/2 cycles later. If it is then high, the block returns to idle and `done_o` and `rx_data_o` keep their values.
- R7: A confirmed reception samples each data bit and the stop bit one period apart, starting from the confirmed start midpoint. The byte is always stored. `frame_err_o` is set to 1 when the stop bit is 0 and to 0 when it is 1, and an accepted start command clears it.
- R8: `done_o` is set when the last slot of a transmitted frame ends, or at the stop-bit sample of a reception. An accepted start command clears it, and so does a confirmed start bit.
- R9: A start command that arrives while `busy_o` is 1 is ignored, together with any change to the mode, the period or the transmit byte.
- R10: `busy_o` rises in the cycle after an accepted start and stays high for exactly S×P cycles. S is 8, 9 or 10 for modes 0, 2 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Framing select (0 clocked, 1 UART, 2 bus, 3 as 0) |
| div_i | input | 12 | Requested bit period in system cycles |
| start_i | input | 1 | Start command strobe, one cycle |
| tx_data_i | input | 8 | Byte to send, captured on an accepted start |
| rx_data_o | output | 8 | Last received byte |
| done_o | output | 1 | Frame complete flag |
| frame_err_o | output | 1 | Stop bit received as 0 |
| busy_o | output | 1 | Frame or reception in progress |
| sck_o | output | 1 | Generated transfer clock, idles high |
| sdo_o | output | 1 | Serial data out, idles high |
| sdi_i | input | 1 | Serial data in |

## Verification
The assertions assume that `sdi_i` is already synchronous to `clk` and that `start_i` is a single-cycle strobe. Each bench task drives `sdi_i` only at the falling clock edge and holds every received bit for a whole number of periods, so the midpoint samples never land on a transition. In clocked and bus mode the data-out pin is looped back to the data-in pin, which lets every transmitted frame predict its own received byte. After a stop bit of 0, the bench waits longer than one period before it checks for idle, because the low tail of that stop bit can briefly look like a new start.

// File: rtl/mmsi_pkg.sv
package mmsi_pkg;

    localparam int DATA_W   = 8;
    localparam int PERIOD_W = 12;
    localparam int SLOT_W   = 4;

    localparam logic [PERIOD_W-1:0] CLK_MIN  = PERIOD_W'(2);
    localparam logic [PERIOD_W-1:0] CLK_MAX  = PERIOD_W'(512);
    localparam logic [PERIOD_W-1:0] UART_MIN = PERIOD_W'(8);
    localparam logic [PERIOD_W-1:0] UART_MAX = PERIOD_W'(2048);

    typedef enum logic [1:0] {
        MODE_SYNC = 2'd0,
        MODE_UART = 2'd1,
        MODE_BUS  = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_HUNT,
        ST_RECV
    } state_e;

    // Per-cycle strobes from the bit-period divider
    typedef struct packed {
        logic lo;    // first half of the bit period
        logic half;  // last cycle of the first half
        logic fin;   // last cycle of the bit period
    } tick_t;

    function automatic mode_e decode_mode(logic [1:0] raw);
        case (raw)
            2'd1:    return MODE_UART;
            2'd2:    return MODE_BUS;
            default: return MODE_SYNC;
        endcase
    endfunction

    function automatic logic [PERIOD_W-1:0] eff_period(mode_e m, logic [PERIOD_W-1:0] req);
        logic [PERIOD_W-1:0] lo_b;
        logic [PERIOD_W-1:0] hi_b;
        lo_b = (m == MODE_UART) ? UART_MIN : CLK_MIN;
        hi_b = (m == MODE_UART) ? UART_MAX : CLK_MAX;
        if (req < lo_b) return lo_b;
        if (req > hi_b) return hi_b;
        return req;
    endfunction

    // Number of slots ahead of the first data bit
    function automatic logic [SLOT_W-1:0] lead_slots(mode_e m);
        return (m == MODE_SYNC) ? SLOT_W'(0) : SLOT_W'(1);
    endfunction

    function automatic logic [SLOT_W-1:0] slot_total(mode_e m);
        case (m)
            MODE_UART: return SLOT_W'(DATA_W + 2);
            MODE_BUS:  return SLOT_W'(DATA_W + 1);
            default:   return SLOT_W'(DATA_W);
        endcase
    endfunction

endpackage

// File: rtl/mmsi_divider.sv
module mmsi_divider
    import mmsi_pkg::*;
#(
    parameter int W = PERIOD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         restart,
    input  logic [W-1:0] period,
    output tick_t        tick
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] half_w;

    assign half_w = period >> 1;

    always_comb begin
        tick.lo   = cnt_q < half_w;
        tick.half = en && (cnt_q == half_w - W'(1));
        tick.fin  = en && (cnt_q == period - W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || restart || !en) begin
            cnt_q <= '0;
        end else if (tick.fin) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt_q < period)); // R10

endmodule

// File: rtl/mmsi_shifter.sv
module mmsi_shifter
    import mmsi_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tx_adv,
    input  logic         rx_adv,
    input  logic         rx_bit,
    output logic         tx_bit,
    output logic [W-1:0] rx_word
);

    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_val;
        end else if (tx_adv) begin
            tx_q <= {1'b0, tx_q[W-1:1]};
        end
    end

    // Least significant bit arrives first, so fill from the top
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= '0;
        end else if (rx_adv) begin
            rx_q <= {rx_bit, rx_q[W-1:1]};
        end
    end

    assign tx_bit  = tx_q[0];
    assign rx_word = rx_q;

    AST_NO_LOAD_MID_SHIFT: assert property (@(posedge clk) disable iff (rst)
        load |-> !tx_adv); // R9

endmodule

// File: rtl/mmsi_ctrl.sv
module mmsi_ctrl
    import mmsi_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [1:0]          mode_i,
    input  logic [PERIOD_W-1:0] div_i,
    input  logic                sdi_i,
    input  tick_t               tick,
    input  logic                tx_bit_i,
    input  logic [DATA_W-1:0]   rx_word_i,
    output logic                div_en_o,
    output logic                div_restart_o,
    output logic [PERIOD_W-1:0] period_o,
    output logic                load_o,
    output logic                tx_adv_o,
    output logic                rx_adv_o,
    output logic                busy_o,
    output logic                sdo_o,
    output logic                sck_o,
    output logic                done_o,
    output logic                ferr_o,
    output logic [DATA_W-1:0]   rx_data_o
);

    state_e              state_q;
    mode_e               mode_q;
    logic [PERIOD_W-1:0] period_q;
    logic [SLOT_W-1:0]   slot_q;
    logic                done_q;
    logic                ferr_q;
    logic [DATA_W-1:0]   rxd_q;

    logic [SLOT_W-1:0] lead;
    logic [SLOT_W-1:0] last_slot;
    logic              data_slot;
    logic              clocked;
    logic              accept;
    logic              hunt_go;
    logic              confirm;

    assign lead      = lead_slots(mode_q);
    assign last_slot = slot_total(mode_q) - SLOT_W'(1);
    assign data_slot = (slot_q >= lead) && (slot_q < lead + SLOT_W'(DATA_W));
    assign clocked   = (mode_q != MODE_UART);

    assign accept  = start_i && (state_q == ST_IDLE);
    assign hunt_go = (state_q == ST_IDLE) && !start_i
                     && (decode_mode(mode_i) == MODE_UART) && !sdi_i;
    assign confirm = (state_q == ST_HUNT) && tick.half && !sdi_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            mode_q   <= MODE_SYNC;
            period_q <= CLK_MIN;
            slot_q   <= '0;
            done_q   <= 1'b0;
            ferr_q   <= 1'b0;
            rxd_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q  <= ST_XFER;
                        mode_q   <= decode_mode(mode_i);
                        period_q <= eff_period(decode_mode(mode_i), div_i);
                        slot_q   <= '0;
                        done_q   <= 1'b0;
                        ferr_q   <= 1'b0;
                    end else if (hunt_go) begin
                        state_q  <= ST_HUNT;
                        mode_q   <= MODE_UART;
                        period_q <= eff_period(MODE_UART, div_i);
                        slot_q   <= '0;
                    end
                end
                ST_XFER: begin
                    if (tick.fin) begin
                        if (slot_q == last_slot) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                            if (clocked) rxd_q <= rx_word_i;
                        end else begin
                            slot_q <= slot_q + SLOT_W'(1);
                        end
                    end
                end
                ST_HUNT: begin
                    if (tick.half) begin
                        if (!sdi_i) begin
                            state_q <= ST_RECV;
                            slot_q  <= '0;
                            done_q  <= 1'b0;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_RECV: begin
                    if (tick.fin) begin
                        if (slot_q == SLOT_W'(DATA_W)) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                            rxd_q   <= rx_word_i;
                            ferr_q  <= !sdi_i;
                        end else begin
                            slot_q <= slot_q + SLOT_W'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign div_en_o      = (state_q != ST_IDLE);
    assign div_restart_o = accept || hunt_go || confirm;
    assign period_o      = period_q;
    assign load_o        = accept;
    assign tx_adv_o      = (state_q == ST_XFER) && tick.fin && data_slot;
    assign rx_adv_o      = ((state_q == ST_XFER) && clocked && data_slot && tick.half)
                        || ((state_q == ST_RECV) && tick.fin && (slot_q < SLOT_W'(DATA_W)));

    always_comb begin
        sdo_o = 1'b1;
        if (state_q == ST_XFER) begin
            if (slot_q < lead)  sdo_o = 1'b0;
            else if (data_slot) sdo_o = tx_bit_i;
        end
    end

    assign sck_o     = !((state_q == ST_XFER) && clocked && tick.lo);
    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = done_q;
    assign ferr_o    = ferr_q;
    assign rx_data_o = rxd_q;

    AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (sdo_o && sck_o)); // R1
    AST_PERIOD_LEGAL: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> ((mode_q == MODE_UART) ? (period_q >= UART_MIN && period_q <= UART_MAX)
                                          : (period_q >= CLK_MIN && period_q <= CLK_MAX))); // R2
    AST_SDO_SLOT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_XFER && $past(state_q == ST_XFER) && !$past(tick.fin)) |-> $stable(sdo_o)); // R3
    AST_UART_CLOCK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (busy_o && mode_q == MODE_UART) |-> sck_o); // R5
    AST_FALSE_START_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HUNT && tick.half && sdi_i) |=> (state_q == ST_IDLE && $stable(done_q) && $stable(rxd_q))); // R6
    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
        accept |=> (!done_o && !ferr_o)); // R8
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> ($stable(mode_q) && $stable(period_q))); // R9

endmodule

// File: rtl/mmsi_top.sv
module mmsi_top
    import mmsi_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          mode_i,
    input  logic [PERIOD_W-1:0] div_i,
    input  logic                start_i,
    input  logic [DATA_W-1:0]   tx_data_i,
    output logic [DATA_W-1:0]   rx_data_o,
    output logic                done_o,
    output logic                frame_err_o,
    output logic                busy_o,
    output logic                sck_o,
    output logic                sdo_o,
    input  logic                sdi_i
);

    tick_t               tick;
    logic                div_en;
    logic                div_restart;
    logic [PERIOD_W-1:0] period;
    logic                load;
    logic                tx_adv;
    logic                rx_adv;
    logic                tx_bit;
    logic [DATA_W-1:0]   rx_word;

    mmsi_divider #(.W(PERIOD_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .en      (div_en),
        .restart (div_restart),
        .period  (period),
        .tick    (tick)
    );

    mmsi_shifter #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (tx_data_i),
        .tx_adv   (tx_adv),
        .rx_adv   (rx_adv),
        .rx_bit   (sdi_i),
        .tx_bit   (tx_bit),
        .rx_word  (rx_word)
    );

    mmsi_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .mode_i        (mode_i),
        .div_i         (div_i),
        .sdi_i         (sdi_i),
        .tick          (tick),
        .tx_bit_i      (tx_bit),
        .rx_word_i     (rx_word),
        .div_en_o      (div_en),
        .div_restart_o (div_restart),
        .period_o      (period),
        .load_o        (load),
        .tx_adv_o      (tx_adv),
        .rx_adv_o      (rx_adv),
        .busy_o        (busy_o),
        .sdo_o         (sdo_o),
        .sck_o         (sck_o),
        .done_o        (done_o),
        .ferr_o        (frame_err_o),
        .rx_data_o     (rx_data_o)
    );

endmodule

// File: tb/mmsi_top_tb_top.sv
`timescale 1ns/1ps
module mmsi_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode;
    logic [11:0] div;
    logic       start;
    logic [7:0] txd;
    logic       sdi_drv;
    logic       loop_en;
    logic       sdi;
    logic [7:0] rx_data;
    logic       done, ferr, busy, sck, sdo;

    always #2 clk = ~clk;

    assign sdi = loop_en ? sdo : sdi_drv;

    mmsi_top dut_i (
        .clk (clk), .rst (rst), .mode_i (mode), .div_i (div), .start_i (start),
        .tx_data_i (txd), .rx_data_o (rx_data), .done_o (done), .frame_err_o (ferr),
        .busy_o (busy), .sck_o (sck), .sdo_o (sdo), .sdi_i (sdi)
    );

    typedef struct {
        logic [7:0] data;
        logic       ferr;
        bit         cmp;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_p(input int m, input int d);
        int lo, hi;
        lo = (m == 1) ? 8 : 2;
        hi = (m == 1) ? 2048 : 512;
        if (d < lo) return lo;
        if (d > hi) return hi;
        return d;
    endfunction

    function automatic int nslots(input int m);
        if (m == 1) return 10;
        if (m == 2) return 9;
        return 8;
    endfunction

    // Monitor: pops the scoreboard on every rising done
    logic done_prev = 1'b0;
    always @(negedge clk) begin
        exp_t e;
        if (rst) begin
            done_prev = 1'b0;
        end else begin
            if (done && !done_prev) begin
                if (sb.size() == 0) begin
                    check(0, "R8", "unexpected done", 1, 0);
                end else begin
                    e = sb.pop_front();
                    if (e.cmp) check(rx_data == e.data, e.tag, "received byte", rx_data, e.data);
                    check(ferr == e.ferr, "R7", "frame error flag", ferr, e.ferr);
                end
            end
            done_prev = done;
        end
    end

    // Driver for transmitted frames; poke>0 issues a stray start mid-frame
    task automatic do_frame(input int m, input int d, input logic [7:0] data, input int poke, input string tag);
        int p, n, j, low, rises, lead;
        logic sck_prev;
        logic cap[10];
        logic acap[10];
        p = exp_p(m == 3 ? 0 : m, d);
        n = nslots(m == 3 ? 0 : m);
        for (int k = 0; k < 10; k++) begin cap[k] = 1'bx; acap[k] = 1'bx; end
        @(negedge clk);
        mode = m[1:0]; div = d[11:0]; txd = data; loop_en = (m != 1); sdi_drv = 1'b1;
        if (m != 1) sb.push_back('{data, 1'b0, 1'b1, tag});
        else        sb.push_back('{8'h00, 1'b0, 1'b0, tag});
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R8", "done cleared by start", done, 0);
        check(ferr == 1'b0, "R7", "error cleared by start", ferr, 0);
        j = 1; low = 0; rises = 0; sck_prev = 1'b1;
        while (busy && j < 30000) begin
            if (!sck) low++;
            if (sck && !sck_prev) begin
                if (rises < 10) cap[rises] = sdo;
                rises++;
            end
            for (int k = 0; k < 10; k++) if (j == k * p + p / 2 + 1) acap[k] = sdo;
            if (poke > 0 && j == poke) begin start = 1'b1; txd = ~data; mode = 2'd2; div = 12'd3; end
            if (poke > 0 && j == poke + 1) start = 1'b0;
            sck_prev = sck;
            j++;
            @(negedge clk);
        end
        check(j - 1 == n * p, "R10", "busy length (also R2 period)", j - 1, n * p);
        check(done == 1'b1, "R8", "done after final slot", done, 1);
        if (m == 1) begin
            check(low == 0, "R5", "clock low cycles", low, 0);
            check(acap[0] == 1'b0, "R5", "start slot level", acap[0], 0);
            for (int i = 0; i < 8; i++)
                check(acap[1 + i] == data[i], "R5", $sformatf("data bit %0d", i), acap[1 + i], data[i]);
            check(acap[9] == 1'b1, "R5", "stop slot level", acap[9], 1);
        end else begin
            lead = (m == 2) ? 1 : 0;
            check(low == n * (p / 2), "R3", "clock low cycles", low, n * (p / 2));
            check(rises == n, "R3", "clock rising edges", rises, n);
            if (m == 2) check(cap[0] == 1'b0, "R4", "start slot level", cap[0], 0);
            for (int i = 0; i < 8; i++)
                check(cap[lead + i] == data[i], (m == 2) ? "R4" : "R3",
                      $sformatf("bit %0d at rising clock", i), cap[lead + i], data[i]);
        end
    endtask

    // Drive a UART frame into sdi
    task automatic rx_frame(input int d, input logic [7:0] data, input logic stopb, input string tag);
        int p;
        p = exp_p(1, d);
        @(negedge clk);
        loop_en = 1'b0; mode = 2'd1; div = d[11:0];
        sb.push_back('{data, ~stopb, 1'b1, tag});
        sdi_drv = 1'b0;
        repeat (p) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            sdi_drv = data[i];
            repeat (p) @(negedge clk);
        end
        sdi_drv = stopb;
        repeat (p) @(negedge clk);
        sdi_drv = 1'b1;
        repeat (p + 4) @(negedge clk);
        check(busy == 1'b0, "R6", "receiver idle after frame", busy, 0);
        check(done == 1'b1, "R8", "done after reception", done, 1);
        check(rx_data == data, "R7", "byte stored", rx_data, data);
        check(ferr == ~stopb, "R7", "stop bit error flag", ferr, ~stopb);
    endtask

    task automatic false_start();
        logic [7:0] keep;
        logic       dkeep;
        keep = rx_data; dkeep = done;
        @(negedge clk);
        loop_en = 1'b0; mode = 2'd1; div = 12'd16;
        sdi_drv = 1'b0;
        repeat (3) @(negedge clk);
        sdi_drv = 1'b1;
        repeat (40) @(negedge clk);
        check(busy == 1'b0, "R6", "idle after glitch", busy, 0);
        check(done == dkeep, "R6", "done kept after glitch", done, dkeep);
        check(rx_data == keep, "R6", "byte kept after glitch", rx_data, keep);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R10 watchdog expired: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        mode = 2'd0; div = 12'd4; start = 1'b0; txd = 8'h00; sdi_drv = 1'b1; loop_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rx_data == 8'h00, "R1", "reset byte", rx_data, 0);
        check(done == 1'b0, "R1", "reset done", done, 0);
        check(ferr == 1'b0, "R1", "reset error", ferr, 0);
        check(busy == 1'b0, "R1", "reset busy", busy, 0);
        check(sdo == 1'b1 && sck == 1'b1, "R1", "idle line levels", {sdo, sck}, 3);

        do_frame(0, 4,   8'hA5, 0, "R3");
        do_frame(0, 1,   8'h3C, 0, "R2");   // clamped to 2
        do_frame(0, 700, 8'h81, 0, "R2");   // clamped to 512
        do_frame(0, 5,   8'h5A, 7, "R9");   // stray start ignored
        do_frame(3, 4,   8'h66, 0, "R3");   // encoding 3 acts as clocked
        do_frame(2, 6,   8'hC3, 0, "R4");
        do_frame(2, 2,   8'h01, 0, "R4");
        do_frame(1, 3,   8'h96, 0, "R5");   // clamped to 8
        do_frame(1, 10,  8'h4B, 0, "R5");
        rx_frame(16, 8'hD2, 1'b1, "R7");
        rx_frame(16, 8'h27, 1'b0, "R7");
        false_start();
        rx_frame(3,  8'hE1, 1'b1, "R6");
        do_frame(0, 3,   8'h7E, 0, "R8");

        repeat (5) @(negedge clk);
        check(sb.size() == 0, "R8", "all frames completed", sb.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule